// File: doc/BRIEF.md
# Block-Granular Preemption Multiplexer for a 66-bit Line

This block sits on a 66-bit line-coded link. It carries two kinds of traffic over one line. One is ordinary frame traffic. The other is latency-critical memory traffic. Every 66-bit word has a 2-bit sync header in bits [65:64] and a 64-bit body in bits [63:0].

On the transmit side, a pending memory word always takes the next line slot. The ordinary stream is held back through a ready/valid handshake for as long as memory words keep arriving. A frame in flight can therefore be split between any two of its words. The transmitter fills an empty slot with an idle word.

On the receive side, each incoming word is sorted by its header and type code:
- Memory words leave at once on their own output.
- Idle words are discarded.
- Unrecognised words are counted and thrown away.
- Every other ordinary word goes into a hold buffer as deep as the longest frame. A frame leaves that buffer a fixed number of cycles after its first word arrived, and then streams out back to back. The memory words that were inserted into it leave no gaps in the output.

The transmit and receive halves share one clock. In a system the transmit line of one end is wired to the receive line of the other end.

Top module: `pmx_link`

## Requirements
- R1: A memory word on the line has header 2'b10, the memory type code (parameter `MEM_CODE`, default 8'hC3) in bits [63:56], and the 56-bit payload in bits [55:0]. Ordinary data words use header 2'b01. Ordinary control words use header 2'b10 with a type in [63:56]: 8'h1E idle, 8'h78 frame start, 8'h4B standalone; 8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1 and 8'hFF close a frame; 8'h2D, 8'h33, 8'h55 and 8'h66 are also ordinary.
- R2: While reset is asserted, `line_tx` is the idle word {2'b10, 8'h1E, 56'h0}, both output valids are low and `drop_count` is zero.
- R3: `std_in_ready` is low in every cycle where `mem_in_valid` is high. After each clock edge, `line_tx` holds one of three words, chosen by what was presented before that edge: the memory word, or else the accepted ordinary word unchanged, or else the idle word.
- R4: A memory word sampled on `line_rx` at an edge appears on `mem_out_valid`/`mem_out_data` right after that edge. It never enters the hold buffer. Measured end to end in loopback, the latency from `mem_in_valid` is two edges.
- R5: Idle words on `line_rx` produce no output on either stream.
- R6: A frame-start word or a standalone ordinary word sampled on `line_rx` at edge e appears on `std_out_block` right after edge e+MAX_FRAME.
- R7: The words of a frame, up to its closing word, leave in their original order, bit-identical, on consecutive cycles. This holds as long as fewer than MAX_FRAME memory words were inserted into the frame.
- R8: A word with header 2'b00 or 2'b11, or with header 2'b10 and a type that is neither an ordinary type nor `MEM_CODE`, produces no output on either stream. It raises `drop_count` by one, and the count saturates at its maximum.
- R9: The hold buffer, with depth MAX_FRAME, never overflows on loopback traffic that obeys R7's insertion limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| std_in_valid | input | 1 | Ordinary transmit word is valid |
| std_in_block | input | 66 | Ordinary transmit word |
| std_in_ready | output | 1 | Ordinary word is taken at this edge |
| mem_in_valid | input | 1 | Memory payload is valid (always taken) |
| mem_in_data | input | 56 | Memory payload |
| line_tx | output | 66 | Transmit line word |
| line_rx | input | 66 | Receive line word |
| mem_out_valid | output | 1 | Received memory payload is valid |
| mem_out_data | output | 56 | Received memory payload |
| std_out_valid | output | 1 | Released ordinary word is valid |
| std_out_block | output | 66 | Released ordinary word |
| drop_count | output | CNT_W | Saturating count of unrecognised words |

## Verification
The bench counts edges, and for every stimulus it computes the cycle in which the result is due:
- the transmit word one edge after presentation;
- a memory payload two edges after `mem_in_valid`, or one edge after a word injected directly onto `line_rx`;
- a frame start or standalone word MAX_FRAME+2 edges after it is accepted on transmit;
- each later word of a frame one edge after the word before it.

The outputs are sampled on the falling edge. At each falling edge the bench compares every output with the entry due in that cycle and requires the output to be silent when nothing is due, so early, late and extra results are all caught. Drops are checked the edge after the bad word was put on the receive line.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int unsigned SH_W   = 2;
  localparam int unsigned BODY_W = 64;
  localparam int unsigned BLK_W  = SH_W + BODY_W;
  localparam int unsigned TYPE_W = 8;
  localparam int unsigned MPAY_W = BODY_W - TYPE_W;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [TYPE_W-1:0] btype_t;

  localparam logic [SH_W-1:0] SH_DATA = 2'b01;
  localparam logic [SH_W-1:0] SH_CTRL = 2'b10;
  localparam btype_t TY_IDLE  = 8'h1E;
  localparam btype_t TY_START = 8'h78;

  typedef enum logic [1:0] {
    KIND_STD  = 2'd0,
    KIND_IDLE = 2'd1,
    KIND_MEM  = 2'd2,
    KIND_BAD  = 2'd3
  } kind_e;

  function automatic btype_t blk_type(input blk_t b);
    return b[BODY_W-1 -: TYPE_W];
  endfunction

  // control types that end a frame
  function automatic logic is_term_type(input btype_t t);
    case (t)
      8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // every control type the ordinary stream may carry
  function automatic logic is_std_type(input btype_t t);
    return is_term_type(t) || (t inside {8'h1E, 8'h2D, 8'h33, 8'h4B, 8'h55, 8'h66, 8'h78});
  endfunction

  function automatic blk_t idle_blk();
    return {SH_CTRL, TY_IDLE, {MPAY_W{1'b0}}};
  endfunction

  function automatic blk_t mem_wrap(input btype_t code, input logic [MPAY_W-1:0] p);
    return {SH_CTRL, code, p};
  endfunction

  function automatic kind_e classify(input blk_t b, input btype_t code);
    if (b[BLK_W-1 -: SH_W] == SH_DATA) return KIND_STD;
    if (b[BLK_W-1 -: SH_W] != SH_CTRL) return KIND_BAD;
    if (blk_type(b) == code)           return KIND_MEM;
    if (blk_type(b) == TY_IDLE)        return KIND_IDLE;
    if (is_std_type(blk_type(b)))      return KIND_STD;
    return KIND_BAD;
  endfunction

  function automatic logic opens_frame(input blk_t b);
    return (b[BLK_W-1 -: SH_W] == SH_CTRL) && (blk_type(b) == TY_START);
  endfunction

  function automatic logic closes_frame(input blk_t b);
    return (b[BLK_W-1 -: SH_W] == SH_CTRL) && is_term_type(blk_type(b));
  endfunction
endpackage

// File: rtl/pmx_tx_arb.sv
module pmx_tx_arb import pmx_pkg::*; #(
  parameter btype_t MEM_CODE = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_valid,
  input  blk_t              std_blk,
  output logic              std_ready,
  input  logic              mem_valid,
  input  logic [MPAY_W-1:0] mem_data,
  output blk_t              line_q,
  output logic              pick_mem,
  output logic              pick_std
);
  blk_t line_d;

  // a memory word always claims the slot
  assign pick_mem  = mem_valid;
  assign pick_std  = std_valid && !mem_valid;
  assign std_ready = !mem_valid;

  always_comb begin
    if (pick_mem)      line_d = mem_wrap(MEM_CODE, mem_data);
    else if (pick_std) line_d = std_blk;
    else               line_d = idle_blk();
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= idle_blk();
    else        line_q <= line_d;
  end
endmodule

// File: rtl/pmx_rx_class.sv
module pmx_rx_class import pmx_pkg::*; #(
  parameter btype_t      MEM_CODE = 8'hC3,
  parameter int unsigned CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  blk_t              line_rx,
  output logic              std_push,
  output blk_t              std_blk,
  output logic              mem_valid,
  output logic [MPAY_W-1:0] mem_data,
  output logic [CNT_W-1:0]  drop_count,
  output logic              bad_evt
);
  kind_e kind;

  assign kind     = classify(line_rx, MEM_CODE);
  assign std_push = (kind == KIND_STD);
  assign std_blk  = line_rx;
  assign bad_evt  = (kind == KIND_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid  <= 1'b0;
      mem_data   <= '0;
      drop_count <= '0;
    end else begin
      mem_valid <= (kind == KIND_MEM);
      mem_data  <= (kind == KIND_MEM) ? line_rx[MPAY_W-1:0] : '0;
      if (bad_evt && (drop_count != '1)) drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/pmx_rx_hold.sv
module pmx_rx_hold import pmx_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned HOLD  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  blk_t push_blk,
  output logic out_valid,
  output blk_t out_blk,
  output logic overflow_evt
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned TW = $clog2(HOLD + 1) + 2;
  localparam logic [TW-1:0] HOLD_T = TW'(HOLD);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);

  blk_t          blk_q [DEPTH];
  logic [TW-1:0] ts_q  [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] now_q;
  logic          in_frame_q;
  logic [TW-1:0] head_age;
  logic          head_ripe, do_pop, do_push;
  blk_t          head_blk;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign head_blk     = blk_q[rd_q];
  assign head_age     = now_q - ts_q[rd_q];
  assign head_ripe    = head_age >= HOLD_T;
  // a frame start waits out the hold, its followers stream behind it
  assign do_pop       = (cnt_q != '0) && (in_frame_q || head_ripe);
  assign do_push      = push && ((cnt_q != FULL) || do_pop);
  assign overflow_evt = push && !do_push;

  always_ff @(posedge clk) begin
    if (do_push) begin
      blk_q[wr_q] <= push_blk;
      ts_q[wr_q]  <= now_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q       <= '0;
      rd_q       <= '0;
      cnt_q      <= '0;
      now_q      <= '0;
      in_frame_q <= 1'b0;
      out_valid  <= 1'b0;
      out_blk    <= '0;
    end else begin
      now_q     <= now_q + 1'b1;
      out_valid <= do_pop;
      out_blk   <= do_pop ? head_blk : '0;
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop) begin
        rd_q <= ptr_inc(rd_q);
        if (opens_frame(head_blk))       in_frame_q <= 1'b1;
        else if (closes_frame(head_blk)) in_frame_q <= 1'b0;
      end
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/pmx_link.sv
module pmx_link import pmx_pkg::*; #(
  parameter int unsigned MAX_FRAME = 16,
  parameter int unsigned CNT_W     = 16,
  parameter btype_t      MEM_CODE  = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_in_valid,
  input  logic [65:0]       std_in_block,
  output logic              std_in_ready,
  input  logic              mem_in_valid,
  input  logic [55:0]       mem_in_data,
  output logic [65:0]       line_tx,
  input  logic [65:0]       line_rx,
  output logic              mem_out_valid,
  output logic [55:0]       mem_out_data,
  output logic              std_out_valid,
  output logic [65:0]       std_out_block,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int unsigned HOLD = MAX_FRAME;

  logic tx_pick_mem, tx_pick_std;
  logic rx_std_push, rx_bad;
  blk_t rx_std_blk;
  logic hold_overflow;

  pmx_tx_arb #(.MEM_CODE(MEM_CODE)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .std_valid(std_in_valid), .std_blk(std_in_block), .std_ready(std_in_ready),
    .mem_valid(mem_in_valid), .mem_data(mem_in_data),
    .line_q(line_tx), .pick_mem(tx_pick_mem), .pick_std(tx_pick_std)
  );

  pmx_rx_class #(.MEM_CODE(MEM_CODE), .CNT_W(CNT_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .line_rx(line_rx),
    .std_push(rx_std_push), .std_blk(rx_std_blk),
    .mem_valid(mem_out_valid), .mem_data(mem_out_data),
    .drop_count(drop_count), .bad_evt(rx_bad)
  );

  pmx_rx_hold #(.DEPTH(MAX_FRAME), .HOLD(HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .push(rx_std_push), .push_blk(rx_std_blk),
    .out_valid(std_out_valid), .out_blk(std_out_block),
    .overflow_evt(hold_overflow)
  );
endmodule

// File: rtl/pmx_link_chk.sv
module pmx_link_chk import pmx_pkg::*; #(
  parameter btype_t      MEM_CODE = 8'hC3,
  parameter int unsigned CNT_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             std_in_valid,
  input logic             std_in_ready,
  input logic [65:0]      std_in_block,
  input logic             mem_in_valid,
  input logic [55:0]      mem_in_data,
  input logic [65:0]      line_tx,
  input logic [65:0]      line_rx,
  input logic             mem_out_valid,
  input logic [55:0]      mem_out_data,
  input logic [CNT_W-1:0] drop_count,
  input logic             rx_std_push,
  input logic             hold_overflow
);
  logic rx_is_mem, rx_is_bad;
  assign rx_is_mem = (line_rx[65:64] == 2'b10) && (line_rx[63:56] == MEM_CODE);
  assign rx_is_bad = (line_rx[65:64] == 2'b00) || (line_rx[65:64] == 2'b11) ||
                     ((line_rx[65:64] == 2'b10) && !rx_is_mem && !is_std_type(line_rx[63:56]));

  a_r1_mem_first: assert property (@(posedge clk) disable iff (!rst_n)
    mem_in_valid |=> (line_tx == {2'b10, MEM_CODE, $past(mem_in_data)}));

  a_r3_std_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (std_in_valid && std_in_ready) |=> (line_tx == $past(std_in_block)));

  a_r3_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!std_in_valid && !mem_in_valid) |=> (line_tx == {2'b10, 8'h1E, 56'h0}));

  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    rx_is_mem |-> !rx_std_push);

  a_r4_mem_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rx_is_mem |=> (mem_out_valid && (mem_out_data == $past(line_rx[55:0]))));

  a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_is_bad && (drop_count != '1)) |=> (drop_count == $past(drop_count) + 1'b1));

  a_r8_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_is_bad |=> $stable(drop_count));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_overflow);
endmodule

bind pmx_link pmx_link_chk #(.MEM_CODE(MEM_CODE), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .std_in_valid(std_in_valid), .std_in_ready(std_in_ready), .std_in_block(std_in_block),
  .mem_in_valid(mem_in_valid), .mem_in_data(mem_in_data),
  .line_tx(line_tx), .line_rx(line_rx),
  .mem_out_valid(mem_out_valid), .mem_out_data(mem_out_data),
  .drop_count(drop_count), .rx_std_push(rx_std_push), .hold_overflow(hold_overflow)
);

// File: tb/test_pmx_link.sv
module test_pmx_link;
  localparam int MAXF = 8;
  localparam logic [7:0] MC = 8'hC3;
  localparam logic [65:0] IDLE = {2'b10, 8'h1E, 56'h0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        std_in_valid = 1'b0;
  logic [65:0] std_in_block = '0;
  logic        std_in_ready;
  logic        mem_in_valid = 1'b0;
  logic [55:0] mem_in_data = '0;
  logic [65:0] line_tx, line_rx;
  logic        mem_out_valid, std_out_valid;
  logic [55:0] mem_out_data;
  logic [65:0] std_out_block;
  logic [15:0] drop_count;
  logic        inj_en = 1'b0;
  logic [65:0] inj_blk = '0;

  assign line_rx = inj_en ? inj_blk : line_tx;

  pmx_link #(.MAX_FRAME(MAXF), .CNT_W(16), .MEM_CODE(MC)) i_pmx_link (
    .clk(clk), .rst_n(rst_n),
    .std_in_valid(std_in_valid), .std_in_block(std_in_block), .std_in_ready(std_in_ready),
    .mem_in_valid(mem_in_valid), .mem_in_data(mem_in_data),
    .line_tx(line_tx), .line_rx(line_rx),
    .mem_out_valid(mem_out_valid), .mem_out_data(mem_out_data),
    .std_out_valid(std_out_valid), .std_out_block(std_out_block),
    .drop_count(drop_count)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  int          m_due[$];
  logic [55:0] m_dat[$];
  int          s_due[$];
  logic [65:0] s_dat[$];
  bit          s_head[$];
  logic [65:0] sq[$];
  int          d_due[$];
  int          drop_exp = 0;
  logic [65:0] exp_line = IDLE;
  bit          exp_line_ok = 0;
  string       exp_lbl = "R3";
  bit          tx_open = 0;
  int          mem_in_fr = 0;
  int          s_last = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [65:0] act, input logic [65:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] term_code(input int i);
    case (i % 8)
      0: return 8'h87; 1: return 8'h99; 2: return 8'hAA; 3: return 8'hB4;
      4: return 8'hCC; 5: return 8'hD2; 6: return 8'hE1; default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic mk_frame(input int len);
    if (len == 1) sq.push_back({2'b10, 8'h4B, rnd64()[55:0]});
    else begin
      sq.push_back({2'b10, 8'h78, rnd64()[55:0]});
      for (int i = 0; i < len - 2; i++) sq.push_back({2'b01, rnd64()});
      sq.push_back({2'b10, term_code($urandom), rnd64()[55:0]});
    end
  endtask

  // expected release cycle of an ordinary word accepted on transmit now
  task automatic note_std(input logic [65:0] b);
    int due;
    if (b == IDLE) return;
    if (tx_open) begin due = s_last + 1; s_head.push_back(1'b0); end
    else begin due = cyc + 2 + MAXF; s_head.push_back(1'b1); end
    s_due.push_back(due);
    s_dat.push_back(b);
    s_last = due;
    if (b[65:64] == 2'b10 && b[63:56] == 8'h78) begin tx_open = 1; mem_in_fr = 0; end
    else if (b[65:64] == 2'b10 && b[63:56] inside {8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF})
      tx_open = 0;
  endtask

  task automatic monitor();
    if (exp_line_ok) chk(line_tx === exp_line, exp_lbl, "line word", line_tx, exp_line);
    while (d_due.size() > 0 && d_due[0] <= cyc) begin drop_exp++; void'(d_due.pop_front()); end
    chk(drop_count == 16'(drop_exp), "R8", "drop count", 66'(drop_count), 66'(drop_exp));
    if (m_due.size() > 0 && m_due[0] <= cyc) begin
      chk(mem_out_valid && mem_out_data == m_dat[0] && m_due[0] == cyc, "R4", "memory payload",
          {9'd0, mem_out_valid, mem_out_data}, {10'd1, m_dat[0]});
      void'(m_due.pop_front()); void'(m_dat.pop_front());
    end else chk(!mem_out_valid, "R4", "unexpected memory output", 66'(mem_out_valid), 66'd0);
    if (s_due.size() > 0 && s_due[0] <= cyc) begin
      chk(std_out_valid && std_out_block == s_dat[0] && s_due[0] == cyc,
          s_head[0] ? "R6" : "R7", "ordinary word", std_out_block, s_dat[0]);
      void'(s_due.pop_front()); void'(s_dat.pop_front()); void'(s_head.pop_front());
    end else chk(!std_out_valid, "R5", "unexpected ordinary output", 66'(std_out_valid), 66'd0);
  endtask

  task automatic tick(input bit mv, input logic [55:0] md);
    monitor();
    mem_in_valid = mv;
    mem_in_data  = md;
    std_in_valid = (sq.size() > 0);
    std_in_block = std_in_valid ? sq[0] : '0;
    #1;
    chk(std_in_ready == !mv, "R3", "ready", 66'(std_in_ready), 66'(!mv));
    if (mv) begin
      exp_line = {2'b10, MC, md}; exp_lbl = "R1";
      m_due.push_back(cyc + 2); m_dat.push_back(md);
      if (tx_open) mem_in_fr++;
    end else if (std_in_valid) begin
      exp_line = sq[0]; exp_lbl = "R3";
      note_std(sq.pop_front());
    end else begin
      exp_line = IDLE; exp_lbl = "R3";
    end
    exp_line_ok = 1;
    @(negedge clk);
  endtask

  // kind: 0 = bad word, 1 = memory word
  task automatic inject(input logic [65:0] b, input int kind);
    monitor();
    mem_in_valid = 0; std_in_valid = 0;
    inj_en = 1; inj_blk = b;
    if (kind == 1) begin m_due.push_back(cyc + 1); m_dat.push_back(b[55:0]); end
    else d_due.push_back(cyc + 1);
    exp_line = IDLE; exp_lbl = "R3";
    @(negedge clk);
    inj_en = 0;
  endtask

  task automatic drain();
    while (sq.size() > 0 || s_due.size() > 0 || m_due.size() > 0) tick(0, '0);
    tick(0, '0); tick(0, '0);
  endtask

  task automatic finish_up();
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done (cycle %0d)", cyc);
      finish_up();
    end
  end

  initial begin
    void'($urandom(17));
    repeat (3) @(negedge clk);
    // R2: reset values
    chk(line_tx == IDLE, "R2", "reset line", line_tx, IDLE);
    chk(!mem_out_valid && !std_out_valid, "R2", "reset valids",
        {64'd0, mem_out_valid, std_out_valid}, 66'd0);
    chk(drop_count == 0, "R2", "reset drops", 66'(drop_count), 66'd0);
    rst_n = 1;
    @(negedge clk);
    exp_line = IDLE; exp_line_ok = 1;

    // every frame length, no preemption
    for (int len = 1; len <= MAXF; len++) begin mk_frame(len); drain(); end

    // random frames with random memory bursts (R7 insertion limit kept)
    for (int f = 0; f < 150; f++) begin
      mk_frame(1 + ($urandom % MAXF));
      while (sq.size() > 0) begin
        bit mv;
        mv = (($urandom % 100) < 35);
        if (tx_open && mem_in_fr >= MAXF - 1) mv = 0;
        tick(mv, {$urandom, $urandom}[55:0]);
      end
      if (($urandom % 4) == 0) tick(1, {$urandom, $urandom}[55:0]);
    end
    drain();

    // boundary: MAXF-1 memory words right after a frame start
    mk_frame(MAXF);
    tick(0, '0);
    for (int i = 0; i < MAXF - 1; i++) tick(1, {$urandom, $urandom}[55:0]);
    drain();

    // long memory burst stalls a queued frame, then back-to-back maximum frames (R9)
    mk_frame(MAXF); mk_frame(MAXF); mk_frame(MAXF); mk_frame(MAXF);
    for (int i = 0; i < 20; i++) tick(1, 56'(i * 32'h01010101));
    while (sq.size() > 0) tick(0, '0);
    drain();
    chk(s_due.size() == 0, "R9", "words left undelivered", 66'(s_due.size()), 66'd0);

    // R5: an idle word offered on the ordinary input yields nothing
    sq.push_back(IDLE);
    drain();

    // R8: unrecognised words; R4: memory word placed directly on the line
    inject({2'b00, 64'h0123_4567_89AB_CDEF}, 0);
    inject({2'b11, 64'hFEDC_BA98_7654_3210}, 0);
    inject({2'b10, 8'h42, 56'h00AB_CDEF_0000_11}, 0);
    inject({2'b10, MC, 56'h5A5A_A5A5_0F0F_F0}, 1);
    inject({2'b10, 8'h00, 56'h1}, 0);
    drain();

    finish_up();
  end
endmodule